// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the eight-bit software status register of a serial flash device. It also rules on every request that would change the register or the memory array. The command decoder sends it the opcode of the current command, a one-cycle strobe when that command completes (chip select rising), the data byte received with it and the target address. The write-protect pin level comes in directly. Busy and sequential-program status come from the neighbouring program engine. The unit returns the assembled status byte, the write-enable latch, and two combinational permits. One permit covers the array operation now presented. The other covers a status write.

Array protection is expressed as a three-bit level that covers a fraction of the address space counted down from its top. A lock bit in the register freezes the protection fields, but only while the write-protect pin is held low. A status write only counts when the command completed directly before it was one of the two enable opcodes.

Top module: `sreg_guard`

## Requirements
- R1: `status_o` is assembled as bit0 = `busy_i`, bit1 = write-enable latch, bits 4:2 = protection level, bit5 = 0, bit6 = `aai_i`, bit7 = lock.
- R2: After reset the protection level is 3'b111, and the lock and the write-enable latch are 0, so `status_o` reads 8'h1C when `busy_i` and `aai_i` are low.
- R3: Protection level 0 covers no address. Level 1 covers addresses with the top three bits all ones (70000h–7FFFFh at the default width). Level 2 covers addresses with the top two bits ones. Level 3 covers addresses with the top bit one. Levels 4 to 7 cover every address.
- R4: A status write (opcode 01h) executes only if `wp_i` is 1 or the lock is 0. An executed write loads the level from data bits 4:2 and the lock from data bit 7. As a result, while `wp_i` is 0 the lock can go from 0 to 1 but never from 1 to 0.
- R5: A status write executes only if the command that completed just before it was 06h or 50h. Otherwise it leaves the register unchanged. A completed 50h does not set the write-enable latch.
- R6: The write-enable latch is set when 06h completes. It is cleared when 04h completes, when a status write executes, when an accepted byte program (02h), sector erase (20h), block erase (D8h) or chip erase (60h/C7h) completes, and when `aai_top_i` pulses. A denied request leaves the latch unchanged.
- R7: A chip erase (60h or C7h) is permitted only when the protection level is 0.
- R8: `array_allow_o` is 1 for 02h, ADh, 20h or D8h only when the latch is set, `busy_i` is 0 and `addr_i` is not covered by the protection level.
- R9: Bits 0, 1, 5 and 6 of the status write data have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_done_i | input | 1 | One-cycle strobe: the command now on `opcode_i` has completed |
| opcode_i | input | 8 | Opcode of the current command |
| wr_data_i | input | 8 | Data byte received with a status write |
| addr_i | input | ADDR_W | Target address of the current command |
| wp_i | input | 1 | Write-protect pin level (1 = high) |
| busy_i | input | 1 | An internal program or erase is running |
| aai_i | input | 1 | Sequential-program mode is active |
| aai_top_i | input | 1 | Pulse: sequential programming reached the top address |
| status_o | output | 8 | Status register contents |
| wel_o | output | 1 | Write-enable latch |
| array_allow_o | output | 1 | The presented array program or erase is permitted |
| sr_allow_o | output | 1 | The presented status write would execute |

## Verification
Every protection level is combined with probe addresses that sit on both sides of the one-half, one-quarter and one-eighth boundaries. This separates an off-by-one decode from a correct one, and shows whether the decode works from the top or from the bottom of the array. Status writes are tried with the pin high and low, with the lock clear and set, after each enable opcode, after a non-enable opcode and with no command before them. This tells the pin gating, the lock direction and the adjacency rule apart. The write data sets every read-only bit, so a leak of any of them into the register shows up. Requests are repeated with the latch clear, with `busy_i` high and on protected addresses, and accepted requests are told apart from denied ones by the latch that follows.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam logic [7:0] OP_SR_WRITE   = 8'h01;
  localparam logic [7:0] OP_PROG_BYTE  = 8'h02;
  localparam logic [7:0] OP_WR_DIS     = 8'h04;
  localparam logic [7:0] OP_WR_EN      = 8'h06;
  localparam logic [7:0] OP_ERASE_4K   = 8'h20;
  localparam logic [7:0] OP_SR_ARM     = 8'h50;
  localparam logic [7:0] OP_ERASE_ALLA = 8'h60;
  localparam logic [7:0] OP_PROG_SEQ   = 8'hAD;
  localparam logic [7:0] OP_ERASE_ALLB = 8'hC7;
  localparam logic [7:0] OP_ERASE_64K  = 8'hD8;

  localparam int unsigned LVL_W = 3;

  typedef struct packed {
    logic             lock;
    logic [LVL_W-1:0] level;
  } prot_t;

  localparam prot_t PROT_RESET = '{lock: 1'b0, level: '1};
endpackage

// File: rtl/sreg_level_decode.sv
module sreg_level_decode #(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [2:0]        level_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned MSB = ADDR_W - 1;

  // Levels 1..3 cover the top 1/8, 1/4, 1/2; bit 2 covers everything.
  always_comb begin
    unique case (level_i[1:0])
      2'b01:   hit_o = &addr_i[MSB -: 3];
      2'b10:   hit_o = &addr_i[MSB -: 2];
      2'b11:   hit_o = addr_i[MSB];
      default: hit_o = 1'b0;
    endcase
    if (level_i[2]) hit_o = 1'b1;
  end
endmodule

// File: rtl/sreg_arm_track.sv
module sreg_arm_track
  import sreg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_done_i,
  input  logic [7:0] opcode_i,
  output logic       armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_o <= 1'b0;
    else if (cmd_done_i) armed_o <= (opcode_i == OP_WR_EN) || (opcode_i == OP_SR_ARM);
  end
endmodule

// File: rtl/sreg_gate.sv
module sreg_gate
  import sreg_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  prot_t      prot_i,
  input  logic       wel_i,
  input  logic       busy_i,
  input  logic       wp_i,
  input  logic       armed_i,
  input  logic       hit_i,
  output logic       addr_wr_o,
  output logic       chip_wr_o,
  output logic       array_allow_o,
  output logic       sr_allow_o
);
  always_comb begin
    addr_wr_o = (opcode_i == OP_PROG_BYTE) || (opcode_i == OP_PROG_SEQ) ||
                (opcode_i == OP_ERASE_4K)  || (opcode_i == OP_ERASE_64K);
    chip_wr_o = (opcode_i == OP_ERASE_ALLA) || (opcode_i == OP_ERASE_ALLB);
    array_allow_o = wel_i && !busy_i &&
                    ((addr_wr_o && !hit_i) || (chip_wr_o && (prot_i.level == '0)));
    sr_allow_o = (opcode_i == OP_SR_WRITE) && armed_i && (wp_i || !prot_i.lock);
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_done_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic              aai_i,
  input  logic              aai_top_i,
  output logic [7:0]        status_o,
  output logic              wel_o,
  output logic              array_allow_o,
  output logic              sr_allow_o
);
  prot_t prot_q;
  logic  wel_q, armed, hit, addr_wr, chip_wr;
  logic  sr_exec, array_done, wel_clr, wel_set;

  sreg_level_decode #(.ADDR_W(ADDR_W)) u_dec (
    .level_i(prot_q.level), .addr_i(addr_i), .hit_o(hit)
  );

  sreg_arm_track u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_done_i(cmd_done_i),
    .opcode_i(opcode_i), .armed_o(armed)
  );

  sreg_gate u_gate (
    .opcode_i(opcode_i), .prot_i(prot_q), .wel_i(wel_q), .busy_i(busy_i),
    .wp_i(wp_i), .armed_i(armed), .hit_i(hit), .addr_wr_o(addr_wr),
    .chip_wr_o(chip_wr), .array_allow_o(array_allow_o), .sr_allow_o(sr_allow_o)
  );

  assign sr_exec    = cmd_done_i && sr_allow_o;
  // Sequential program keeps the latch; its end comes via aai_top_i or 04h.
  assign array_done = cmd_done_i && array_allow_o && (opcode_i != OP_PROG_SEQ);
  assign wel_clr    = aai_top_i || sr_exec || array_done ||
                      (cmd_done_i && (opcode_i == OP_WR_DIS));
  assign wel_set    = cmd_done_i && (opcode_i == OP_WR_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= PROT_RESET;
    end else if (sr_exec) begin
      prot_q.level <= wr_data_i[4:2];
      prot_q.lock  <= wr_data_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wel_q <= 1'b0;
    else if (wel_clr) wel_q <= 1'b0;
    else if (wel_set) wel_q <= 1'b1;
  end

  assign wel_o    = wel_q;
  assign status_o = {prot_q.lock, aai_i, 1'b0, prot_q.level, wel_q, busy_i};

  p_wel_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && (opcode_i == OP_WR_EN) && !aai_top_i |=> wel_o);
  p_wel_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && (opcode_i == OP_WR_DIS) |=> !wel_o);
  p_lock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && !wp_i && status_o[7] |=> $stable(status_o[7:2]));
  p_unarmed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i && (opcode_i == OP_SR_WRITE) && !armed |=> $stable(status_o[7:2]));
  p_chip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_allow_o && chip_wr |-> (status_o[4:2] == 3'b000));
  p_busy_deny_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !array_allow_o);
  p_prot_deny_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr && hit |-> !array_allow_o);
endmodule

// File: tb/sreg_guard_tb.sv
module sreg_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk = 0, rst_n = 0;
  logic          done_s = 0, wp = 1, busy = 0, aai = 0, aai_top = 0;
  logic [7:0]    opcode = 8'h00, data = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          wel, arr_ok, sr_ok;

  int n_total = 0, n_fail = 0;
  bit finished = 0;

  logic [2:0] m_bp = 3'b111;
  logic       m_bpl = 0, m_wel = 0, m_armed = 0;

  typedef struct {string tag; int sel; logic [7:0] exp;} item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_guard #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_done_i(done_s), .opcode_i(opcode),
    .wr_data_i(data), .addr_i(addr), .wp_i(wp), .busy_i(busy), .aai_i(aai),
    .aai_top_i(aai_top), .status_o(status), .wel_o(wel),
    .array_allow_o(arr_ok), .sr_allow_o(sr_ok)
  );

  // Monitor: pops expected items and compares them with the ports.
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        0: act = status;
        1: act = {7'b0, wel};
        2: act = {7'b0, arr_ok};
        default: act = {7'b0, sr_ok};
      endcase
      n_total++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic bit covered(logic [2:0] bp, logic [AW-1:0] a);
    case (bp)
      3'd0: covered = 0;
      3'd1: covered = (a >= 19'h70000);
      3'd2: covered = (a >= 19'h60000);
      3'd3: covered = (a >= 19'h40000);
      default: covered = 1;
    endcase
  endfunction

  task automatic expect_v(string tag, int sel, logic [7:0] e);
    q.push_back('{tag, sel, e});
    @(negedge clk); #1;
  endtask

  task automatic chk_status(string tag);
    expect_v(tag, 0, {m_bpl, aai, 1'b0, m_bp, m_wel, busy});
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] d, logic [AW-1:0] a);
    bit sr_x, ar_x, adr, chip;
    @(posedge clk); #1;
    opcode = op; data = d; addr = a; done_s = 1;
    @(posedge clk); #1;
    done_s = 0;
    adr  = (op == 8'h02) || (op == 8'hAD) || (op == 8'h20) || (op == 8'hD8);
    chip = (op == 8'h60) || (op == 8'hC7);
    sr_x = (op == 8'h01) && m_armed && (wp || !m_bpl);
    ar_x = m_wel && !busy && ((adr && !covered(m_bp, a)) || (chip && m_bp == 0));
    if (sr_x) begin m_bp = d[4:2]; m_bpl = d[7]; end
    if (op == 8'h04 || sr_x || (ar_x && op != 8'hAD)) m_wel = 0;
    else if (op == 8'h06) m_wel = 1;
    m_armed = (op == 8'h06) || (op == 8'h50);
    opcode = 8'h00;
  endtask

  task automatic probe(logic [7:0] op, logic [AW-1:0] a, string tag, int sel, logic e);
    opcode = op; addr = a;
    expect_v(tag, sel, {7'b0, e});
    opcode = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pts [8];
    pts = '{19'h00000, 19'h3FFFF, 19'h40000, 19'h5FFFF,
            19'h60000, 19'h6FFFF, 19'h70000, 19'h7FFFF};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk_status("R2 reset status 1C");
    expect_v("R2 reset latch", 1, 8'h00);
    busy = 1; aai = 1;
    chk_status("R1 busy and aai bits");
    busy = 0; aai = 0;
    probe(8'h02, 19'h00000, "R8 latch clear denies", 2, 0);

    cmd(8'h06, 0, 0);
    expect_v("R6 06 sets latch", 1, 8'h01);
    cmd(8'h01, 8'h00, 0);
    chk_status("R4 R6 armed write with pin high, latch cleared");
    cmd(8'h01, 8'h1C, 0);
    chk_status("R5 write without preceding enable ignored");
    cmd(8'h06, 0, 0);
    cmd(8'h04, 0, 0);
    expect_v("R6 04 clears latch", 1, 8'h00);
    cmd(8'h01, 8'h1C, 0);
    chk_status("R5 write after 04 ignored");
    cmd(8'h50, 0, 0);
    chk_status("R5 50 leaves latch clear");
    cmd(8'h01, 8'hFF, 0);
    chk_status("R9 read-only data bits dropped, lock set");
    expect_v("R9 status 9C", 0, 8'h9C);

    wp = 0;
    cmd(8'h06, 0, 0);
    probe(8'h01, 0, "R4 permit low while locked and pin low", 3, 0);
    cmd(8'h01, 8'h00, 0);
    chk_status("R4 locked write ignored, latch kept");
    cmd(8'h04, 0, 0);
    wp = 1;
    cmd(8'h50, 0, 0);
    probe(8'h01, 0, "R4 permit high with pin high", 3, 1);
    cmd(8'h01, 8'h04, 0);
    chk_status("R4 pin high unlocks");
    wp = 0;
    cmd(8'h50, 0, 0);
    cmd(8'h01, 8'h84, 0);
    chk_status("R4 lock 0 to 1 with pin low");
    wp = 1;
    cmd(8'h50, 0, 0);
    cmd(8'h01, 8'h00, 0);
    chk_status("R4 cleared with pin high");
    cmd(8'h20, 0, 0);
    probe(8'h50, 0, "R5 arm", 3, 0);
    cmd(8'h50, 0, 0);
    cmd(8'h05, 0, 0);
    cmd(8'h01, 8'h08, 0);
    chk_status("R5 enable wasted by intervening command");

    for (int bp = 0; bp < 8; bp++) begin
      cmd(8'h50, 0, 0);
      cmd(8'h01, {3'b000, 3'(bp), 2'b00}, 0);
      cmd(8'h06, 0, 0);
      chk_status("R3 level loaded");
      for (int j = 0; j < 8; j++)
        probe(8'h02, pts[j], $sformatf("R3 level %0d addr %h", bp, pts[j]), 2,
              !covered(3'(bp), pts[j]));
      probe(8'h60, 0, $sformatf("R7 chip erase at level %0d", bp), 2, bp == 0);
      probe(8'hC7, 0, $sformatf("R7 alt chip erase at level %0d", bp), 2, bp == 0);
    end

    cmd(8'h02, 0, 19'h00000);
    expect_v("R8 R6 protected program denied, latch kept", 1, 8'h01);
    cmd(8'h50, 0, 0);
    cmd(8'h01, 8'h00, 0);
    cmd(8'h06, 0, 0);
    busy = 1;
    probe(8'h02, 19'h00000, "R8 busy denies", 2, 0);
    busy = 0;
    cmd(8'h02, 0, 19'h12345);
    expect_v("R6 accepted program clears latch", 1, 8'h00);
    cmd(8'h06, 0, 0);
    cmd(8'hAD, 0, 19'h00000);
    expect_v("R6 sequential start keeps latch", 1, 8'h01);
    @(posedge clk); #1 aai_top = 1;
    @(posedge clk); #1 aai_top = 0;
    m_wel = 0;
    expect_v("R6 top address pulse clears latch", 1, 8'h00);
    cmd(8'h06, 0, 0);
    cmd(8'hD8, 0, 19'h20000);
    expect_v("R6 accepted block erase clears latch", 1, 8'h00);
    cmd(8'h06, 0, 0);
    cmd(8'h60, 0, 0);
    expect_v("R7 R6 accepted chip erase clears latch", 1, 8'h00);
    chk_status("R1 final status");

    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule